// File: doc/BRIEF.md
# 1-for-1 Protection Selector

This block is the master-side switch of a 1-for-1 multiplex-section protection pair. It receives two byte-wide streams: one from the local section terminator and one from the partner (slave) terminator over an 8-bit protection bus. It forwards one of them downstream. It also extracts the partner's two protection-signalling overhead bytes from the bus, using strobes that mark their byte positions. It registers the partner's degrade and fail indications, and raises a one-cycle event whenever any of these four values changes.

The choice of stream is made by software through a command bit. The command takes effect only on a frame boundary. A separate output reports the position actually in effect, so software can tell a pending command from an applied one.

When the block is configured as a slave, it makes no selection. It drives the local stream onto the protection bus for the master and freezes its extraction logic.

Top module: `prot_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register is cleared: `data_out`, `pbus_out`, `slv_k1`, `slv_k2`, `slv_stat`, `chg_evt` and `sw_eff` all read 0 after that edge.
- R2: In master mode (`master_en`=1), a clock edge with `pbus_k1_stb` high loads `pbus_in` into `slv_k1`, and one with `pbus_k2_stb` high loads it into `slv_k2`. The new value is visible after that edge. Without its strobe, each register holds.
- R3: `chg_evt[0]` (first byte) and `chg_evt[1]` (second byte) go high for exactly the one cycle following a load whose value differs from the held value. They stay low when the loaded value is equal, and when no load occurs.
- R4: In master mode, `slv_stat[0]` takes `slv_sd` and `slv_stat[1]` takes `slv_sf` at every clock edge. `chg_evt[2]` (SD) and `chg_evt[3]` (SF) pulse for one cycle when the newly registered bit differs from the previous one.
- R5: In master mode, `sw_eff` takes the value of `sw_cmd` only at a clock edge where `frame_start` is high. At all other edges it holds. Here 0 means local and 1 means protection bus.
- R6: `data_out` is registered. After each edge it holds `pbus_in` if the `sw_eff` produced by that same edge is 1, and `loc_data` otherwise. The byte sampled with `frame_start` therefore already comes from the newly applied stream.
- R7: In slave mode (`master_en`=0), `sw_eff` is cleared and `data_out` follows `loc_data` with one cycle of latency. `pbus_out` carries `loc_data` with one cycle of latency. `slv_k1`, `slv_k2` and `slv_stat` hold, and `chg_evt` is 0. In master mode `pbus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1 = master (selects), 0 = slave (forwards local data) |
| loc_data | input | 8 | Byte stream from the local section terminator |
| frame_start | input | 1 | Frame-boundary strobe; switch commands apply here |
| pbus_in | input | 8 | Byte stream from the partner over the protection bus |
| pbus_k1_stb | input | 1 | Marks the first protection byte on `pbus_in` |
| pbus_k2_stb | input | 1 | Marks the second protection byte on `pbus_in` |
| slv_sd | input | 1 | Partner signal-degrade indication |
| slv_sf | input | 1 | Partner signal-fail indication |
| sw_cmd | input | 1 | Software switch command: 0 local, 1 protection bus |
| data_out | output | 8 | Selected byte stream |
| pbus_out | output | 8 | Local stream driven towards the master in slave mode |
| slv_k1 | output | 8 | Held first protection byte of the partner |
| slv_k2 | output | 8 | Held second protection byte of the partner |
| slv_stat | output | 2 | Registered partner status: bit 0 SD, bit 1 SF |
| chg_evt | output | 4 | One-cycle change events: K1, K2, SD, SF |
| sw_eff | output | 1 | Switch position in effect |

## Verification
Both protection-byte registers are swept through all 256 values, and each value is then presented a second time. This separates a real change from a repeated load, and a strobed edge from an idle one. The degrade and fail inputs step through all sixteen ordered pairs of two-bit states, so each event bit is seen alone, together with the other bit, and absent. The switch is driven with the command toggling both on and off frame boundaries, while the two streams carry complementary counting bytes, so any byte taken from the wrong stream, or any change applied one cycle early or late, shows in `data_out`. A slave-mode pass keeps the strobes and status inputs active to show that nothing is captured and that the local stream reaches the bus.

// File: rtl/prot_sel_pkg.sv
// Shared definitions for the 1-for-1 protection selector.
// Assumes: event vector order is first byte, second byte, then status bits.
package prot_sel_pkg;
    localparam int NUM_KBYTES = 2;
    localparam int NUM_STAT   = 2;
    localparam int NUM_EVT    = NUM_KBYTES + NUM_STAT;

    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_PROT  = 1'b1
    } src_e;
endpackage

// File: rtl/prot_sel_kcap.sv
// Captures one overhead byte from the protection bus when its position
// strobe is high and capture is enabled; pulses a change event for one
// cycle when the captured value differs from the held one.
// Assumes: strobe is high for exactly the byte to be taken.
module prot_sel_kcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q,
    output logic          evt
);
    // Hold register and one-cycle change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            evt <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (en && stb) begin
                evt <= (din != q);
                q   <= din;
            end
        end
    end
endmodule

// File: rtl/prot_sel_stat.sv
// Registers the partner's status bits every cycle while enabled and
// flags each bit that changed with a one-cycle pulse.
// Assumes: inputs are already synchronous to clk.
module prot_sel_stat #(
    parameter int NS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NS-1:0] din,
    output logic [NS-1:0] q,
    output logic [NS-1:0] evt
);
    // Status capture and per-bit change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            evt <= '0;
        end else if (en) begin
            q   <= din;
            evt <= din ^ q;
        end else begin
            evt <= '0;
        end
    end
endmodule

// File: rtl/prot_sel_switch.sv
// Applies the software switch command at frame boundaries, selects the
// forwarded stream and drives local data onto the bus in slave mode.
// Assumes: frame_start is a single-cycle strobe.
module prot_sel_switch
    import prot_sel_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic          frame_start,
    input  logic          sw_cmd,
    input  logic [DW-1:0] loc_data,
    input  logic [DW-1:0] pbus_in,
    output logic [DW-1:0] data_out,
    output logic [DW-1:0] pbus_out,
    output logic          sw_eff
);
    src_e cur_src;
    src_e nxt_src;

    // Next position: forced local in slave mode, updated only on a boundary.
    always_comb begin
        if (!master_en)
            nxt_src = SRC_LOCAL;
        else if (frame_start)
            nxt_src = src_e'(sw_cmd);
        else
            nxt_src = cur_src;
    end

    // Position, selected data and bus output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src  <= SRC_LOCAL;
            data_out <= '0;
            pbus_out <= '0;
        end else begin
            cur_src  <= nxt_src;
            data_out <= (nxt_src == SRC_PROT) ? pbus_in : loc_data;
            pbus_out <= master_en ? '0 : loc_data;
        end
    end

    assign sw_eff = (cur_src == SRC_PROT);
endmodule

// File: rtl/prot_sel.sv
// Top of the 1-for-1 protection selector: byte capture, status capture
// and stream switch.
// Assumes: one byte per clock on both streams, aligned to one clock.
module prot_sel
    import prot_sel_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_en,
    input  logic [DW-1:0]      loc_data,
    input  logic               frame_start,
    input  logic [DW-1:0]      pbus_in,
    input  logic               pbus_k1_stb,
    input  logic               pbus_k2_stb,
    input  logic               slv_sd,
    input  logic               slv_sf,
    input  logic               sw_cmd,
    output logic [DW-1:0]      data_out,
    output logic [DW-1:0]      pbus_out,
    output logic [DW-1:0]      slv_k1,
    output logic [DW-1:0]      slv_k2,
    output logic [NUM_STAT-1:0] slv_stat,
    output logic [NUM_EVT-1:0] chg_evt,
    output logic               sw_eff
);
    logic [NUM_KBYTES-1:0]         kb_stb;
    logic [NUM_KBYTES-1:0][DW-1:0] kb_q;
    logic [NUM_KBYTES-1:0]         kb_evt;
    logic [NUM_STAT-1:0]           st_evt;

    assign kb_stb = {pbus_k2_stb, pbus_k1_stb};

    // One capture unit per protection byte.
    for (genvar i = 0; i < NUM_KBYTES; i++) begin : g_kcap
        prot_sel_kcap #(.DW(DW)) u_kcap (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (master_en),
            .stb   (kb_stb[i]),
            .din   (pbus_in),
            .q     (kb_q[i]),
            .evt   (kb_evt[i])
        );
    end

    prot_sel_stat #(.NS(NUM_STAT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (master_en),
        .din   ({slv_sf, slv_sd}),
        .q     (slv_stat),
        .evt   (st_evt)
    );

    prot_sel_switch #(.DW(DW)) u_sw (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en   (master_en),
        .frame_start (frame_start),
        .sw_cmd      (sw_cmd),
        .loc_data    (loc_data),
        .pbus_in     (pbus_in),
        .data_out    (data_out),
        .pbus_out    (pbus_out),
        .sw_eff      (sw_eff)
    );

    assign slv_k1  = kb_q[0];
    assign slv_k2  = kb_q[1];
    assign chg_evt = {st_evt, kb_evt};
endmodule

// File: rtl/prot_sel_chk.sv
// Assertion checker for prot_sel, attached with bind.
module prot_sel_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_en,
    input logic [DW-1:0] loc_data,
    input logic          frame_start,
    input logic [DW-1:0] pbus_in,
    input logic          pbus_k1_stb,
    input logic          pbus_k2_stb,
    input logic          slv_sd,
    input logic          slv_sf,
    input logic          sw_cmd,
    input logic [DW-1:0] pbus_out,
    input logic [DW-1:0] slv_k1,
    input logic [DW-1:0] slv_k2,
    input logic [1:0]    slv_stat,
    input logic [3:0]    chg_evt,
    input logic          sw_eff
);
    // R2: without its strobe the first byte holds
    a_r2_k1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pbus_k1_stb |=> $stable(slv_k1));
    // R2: without its strobe the second byte holds
    a_r2_k2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pbus_k2_stb |=> $stable(slv_k2));
    // R3: differing load gives one event pulse and the new value
    a_r3_k1_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && pbus_k1_stb && pbus_in != slv_k1) |=>
            (chg_evt[0] && slv_k1 == $past(pbus_in)));
    // R3: no load, no first-byte event
    a_r3_k1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pbus_k1_stb |=> !chg_evt[0]);
    // R4: status follows its inputs in master mode
    a_r4_stat: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |=> slv_stat == $past({slv_sf, slv_sd}));
    // R5: position changes only on a frame boundary in master mode
    a_r5_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !frame_start) |=> $stable(sw_eff));
    // R7: slave mode clears the position and forwards local data
    a_r7_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!sw_eff && pbus_out == $past(loc_data) && chg_evt == 4'b0));
endmodule

bind prot_sel prot_sel_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .loc_data    (loc_data),
    .frame_start (frame_start),
    .pbus_in     (pbus_in),
    .pbus_k1_stb (pbus_k1_stb),
    .pbus_k2_stb (pbus_k2_stb),
    .slv_sd      (slv_sd),
    .slv_sf      (slv_sf),
    .sw_cmd      (sw_cmd),
    .pbus_out    (pbus_out),
    .slv_k1      (slv_k1),
    .slv_k2      (slv_k2),
    .slv_stat    (slv_stat),
    .chg_evt     (chg_evt),
    .sw_eff      (sw_eff)
);

// File: tb/prot_sel_test.sv
// Self-checking bench for prot_sel: sweeps bytes, status pairs, switch
// timing and slave mode against a model built from the requirements.
module prot_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b1;
    logic [7:0] loc_data = '0;
    logic       frame_start = 1'b0;
    logic [7:0] pbus_in = '0;
    logic       k1s = 1'b0, k2s = 1'b0;
    logic       sd = 1'b0, sf = 1'b0, cmd = 1'b0;
    logic [7:0] data_out, pbus_out, slv_k1, slv_k2;
    logic [1:0] slv_stat;
    logic [3:0] chg_evt;
    logic       sw_eff;

    int total = 0;
    int bad = 0;

    // expected state
    logic [7:0] m_k1 = '0, m_k2 = '0, m_dout = '0, m_pout = '0;
    logic [1:0] m_stat = '0;
    logic [3:0] m_evt = '0;
    logic       m_eff = 1'b0;

    always #2 clk = ~clk;

    prot_sel uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .loc_data(loc_data),
        .frame_start(frame_start), .pbus_in(pbus_in), .pbus_k1_stb(k1s),
        .pbus_k2_stb(k2s), .slv_sd(sd), .slv_sf(sf), .sw_cmd(cmd),
        .data_out(data_out), .pbus_out(pbus_out), .slv_k1(slv_k1),
        .slv_k2(slv_k2), .slv_stat(slv_stat), .chg_evt(chg_evt), .sw_eff(sw_eff)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock with current inputs, update the model, compare.
    task automatic tick();
        logic eff_n;
        if (!rst_n) begin
            m_k1 = '0; m_k2 = '0; m_stat = '0; m_evt = '0;
            m_eff = 1'b0; m_dout = '0; m_pout = '0;
        end else if (master_en) begin
            m_evt = '0;
            if (k1s) begin m_evt[0] = (pbus_in != m_k1); m_k1 = pbus_in; end
            if (k2s) begin m_evt[1] = (pbus_in != m_k2); m_k2 = pbus_in; end
            m_evt[2] = (sd != m_stat[0]);
            m_evt[3] = (sf != m_stat[1]);
            m_stat = {sf, sd};
            eff_n = frame_start ? cmd : m_eff;
            m_dout = eff_n ? pbus_in : loc_data;
            m_eff = eff_n;
            m_pout = '0;
        end else begin
            m_evt = '0;
            m_eff = 1'b0;
            m_dout = loc_data;
            m_pout = loc_data;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rst_n ? "R2 k1" : "R1 k1", slv_k1, m_k1);
        chk(rst_n ? "R2 k2" : "R1 k2", slv_k2, m_k2);
        chk(rst_n ? "R3 byte events" : "R1 events", {6'b0, chg_evt[1:0]}, {6'b0, m_evt[1:0]});
        chk("R4 status events", {6'b0, chg_evt[3:2]}, {6'b0, m_evt[3:2]});
        chk("R4 status", {6'b0, slv_stat}, {6'b0, m_stat});
        chk("R5 sw_eff", {7'b0, sw_eff}, {7'b0, m_eff});
        chk("R6 data_out", data_out, m_dout);
        chk("R7 pbus_out", pbus_out, m_pout);
    endtask

    initial begin : watchdog
        #400000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        // R1: reset state
        tick(); tick();
        rst_n = 1'b1;
        // R2 R3: first byte, every value then a repeat of it
        for (int v = 1; v < 257; v++) begin
            pbus_in = 8'(v); k1s = 1'b1; tick();
            k1s = 1'b0; pbus_in = 8'(v + 37); tick();
            k1s = 1'b1; pbus_in = 8'(v); tick();
            k1s = 1'b0;
        end
        // R2 R3: second byte
        for (int v = 0; v < 256; v++) begin
            pbus_in = 8'(255 - v); k2s = 1'b1; tick();
            tick();
            k2s = 1'b0;
        end
        // R4: all ordered pairs of status states
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                {sf, sd} = 2'(a); tick();
                {sf, sd} = 2'(b); tick();
            end
        end
        // R5 R6: command toggling on and off boundaries, complementary streams
        for (int i = 0; i < 400; i++) begin
            loc_data = 8'(i);
            pbus_in = ~8'(i);
            frame_start = (i % 9) == 0;
            cmd = ((i / 5) % 3) == 1;
            tick();
        end
        frame_start = 1'b0;
        // R7: slave mode with strobes and status active
        master_en = 1'b0;
        for (int i = 0; i < 120; i++) begin
            loc_data = 8'(3 * i + 1);
            pbus_in = 8'(i ^ 8'h5a);
            k1s = i[0]; k2s = i[1];
            {sf, sd} = 2'(i);
            frame_start = (i % 4) == 0;
            cmd = 1'b1;
            tick();
        end
        // return to master: position must start local until a boundary
        master_en = 1'b1; k1s = 1'b0; k2s = 1'b0;
        for (int i = 0; i < 20; i++) begin
            loc_data = 8'(i); pbus_in = 8'(200 + i);
            frame_start = (i == 7);
            tick();
        end
        // R1: reset while running
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule